// File: doc/BRIEF.md
# Cache Enable and Flush Controller

This block sequences the on/off state of a split instruction cache and data cache. Software writes a configuration word that holds one enable bit per cache, and it reads back a status word. A 1 in an enable bit turns that cache on at once. A 0 in the enable bit of an active cache removes caching permission and starts a sweep. The sweep clears the cache's valid bits one line per cycle, through a strobe and a line index.

A cache stays reported as active until its sweep is complete. Software must therefore poll the status word until the cache's active bit is 0 before it turns the cache back on. An enable written while a sweep is still running is dropped. The two caches sweep on their own schedules, and their sweeps may overlap.

The status word also reports a lock flag for each cache, taken from external lock inputs. Each flag is shown only while the lock function is switched on.

Top module: `cfc_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0, the status word reads 0 while the lock function is off, both caching-allowed outputs are 0 and neither clear strobe is asserted.
- R2: A write to address 0 with bit 1 (instruction) or bit 0 (data) set turns that idle cache on. From the next cycle its enable bit reads 1, its active status bit reads 1 and its caching-allowed output is 1.
- R3: A write of 0 to the enable bit of an active cache drops its caching-allowed output on the next cycle and starts a sweep. The clear strobe is high for exactly LINES consecutive cycles, with the index counting 0, 1, ..., LINES-1. LINES is 16 for the instruction cache and 8 for the data cache by default.
- R4: After the disabling write, the enable bit reads 0 at once. The active status bit reads 1 for exactly LINES cycles and then reads 0.
- R5: A write of 1 to the enable bit of a cache whose sweep is running has no effect, including a write in the sweep's final cycle. The enable bit and the caching-allowed output stay 0, and the sweep runs to its end.
- R6: The instruction and data sweeps run independently and may overlap. Each one clears only its own lines and keeps its own length.
- R7: Status word layout at address 1: bit 3 is instruction lock, bit 2 is data lock, bit 1 is instruction active, bit 0 is data active. Bits 31:4 read 0.
- R8: Each lock bit equals its lock input while the lock-function input is 1, and reads 0 while it is 0.
- R9: Configuration word at address 0: bit 1 is instruction enable, bit 0 is data enable, and all other bits read 0. Writes to address 1 change nothing.
- R10: Writing 0 to the enable bit of an idle cache starts no sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 configuration, 1 status |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| lock_fn_en_i | input | 1 | Lock function switched on |
| ic_lock_i | input | 1 | Instruction cache locked |
| dc_lock_i | input | 1 | Data cache locked |
| ic_allow_o | output | 1 | Instruction caching allowed |
| dc_allow_o | output | 1 | Data caching allowed |
| ic_vclr_o | output | 1 | Instruction valid-bit clear strobe |
| ic_vclr_idx_o | output | IC_IDX_W | Instruction line being cleared |
| dc_vclr_o | output | 1 | Data valid-bit clear strobe |
| dc_vclr_idx_o | output | DC_IDX_W | Data line being cleared |

## Verification
Two things can land in the same cycle: a software enable write and the last cycle of that cache's sweep. The bench times an enable write so that the clock edge which samples it is the one on which the index reaches LINES-1. It then expects the enable bit, the active bit and the caching-allowed output all to read 0 afterwards. A second case has the data sweep start while the instruction sweep is running. A scoreboard queue per cache holds the expected clear indices, so that each strobe is matched to its own cache, and any strobe that was not predicted counts as a mismatch.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    CS_OFF   = 2'd0,
    CS_ON    = 2'd1,
    CS_FLUSH = 2'd2
  } cache_state_e;

  localparam int REG_W = 32;

  // register select values
  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // configuration word bit positions
  localparam int CFG_DC_BIT = 0;
  localparam int CFG_IC_BIT = 1;

  // status word bit positions
  localparam int ST_DC_ACT = 0;
  localparam int ST_IC_ACT = 1;
  localparam int ST_DC_LCK = 2;
  localparam int ST_IC_LCK = 3;

  // true on the final line of a sweep
  function automatic logic sweep_last(input int idx, input int lines);
    return idx == lines - 1;
  endfunction

  // lock flag seen by software
  function automatic logic lock_seen(input logic lk, input logic fn_en);
    return lk & fn_en;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic ilk, input logic dlk,
                                                   input logic iact, input logic dact);
    logic [REG_W-1:0] w;
    w = '0;
    w[ST_IC_LCK] = ilk;
    w[ST_DC_LCK] = dlk;
    w[ST_IC_ACT] = iact;
    w[ST_DC_ACT] = dact;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input logic ien, input logic den);
    logic [REG_W-1:0] w;
    w = '0;
    w[CFG_IC_BIT] = ien;
    w[CFG_DC_BIT] = den;
    return w;
  endfunction

endpackage

// File: rtl/cfc_flush_engine.sv
module cfc_flush_engine
  import cfc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_on_i,
  input  logic             req_off_i,
  output logic             on_o,
  output logic             active_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             sweep_done_o,
  output logic             on_refused_o
);

  cache_state_e     st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last = sweep_last(int'(idx_q), LINES);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      CS_OFF: if (req_on_i) st_d = CS_ON;
      CS_ON: begin
        if (req_off_i) begin
          st_d  = CS_FLUSH;
          idx_d = '0;
        end
      end
      CS_FLUSH: begin
        if (last) begin
          st_d  = CS_OFF;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = CS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CS_OFF;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign on_o         = (st_q == CS_ON);
  assign active_o     = (st_q != CS_OFF);
  assign clr_o        = (st_q == CS_FLUSH);
  assign clr_idx_o    = idx_q;
  assign sweep_done_o = clr_o & last;
  assign on_refused_o = clr_o & req_on_i;

endmodule

// File: rtl/cfc_regport.sv
module cfc_regport
  import cfc_pkg::*;
(
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ic_on_i,
  input  logic             dc_on_i,
  input  logic             ic_act_i,
  input  logic             dc_act_i,
  input  logic             ic_lk_i,
  input  logic             dc_lk_i,
  input  logic             lk_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             ic_on_req_o,
  output logic             ic_off_req_o,
  output logic             dc_on_req_o,
  output logic             dc_off_req_o
);

  logic cfg_hit;
  logic unused_wdata;

  assign cfg_hit = wr_i && (addr_i == ADDR_CFG);

  assign ic_on_req_o  = cfg_hit &&  wdata_i[CFG_IC_BIT];
  assign ic_off_req_o = cfg_hit && !wdata_i[CFG_IC_BIT];
  assign dc_on_req_o  = cfg_hit &&  wdata_i[CFG_DC_BIT];
  assign dc_off_req_o = cfg_hit && !wdata_i[CFG_DC_BIT];

  assign rdata_o = (addr_i == ADDR_STAT)
                 ? pack_status(lock_seen(ic_lk_i, lk_en_i), lock_seen(dc_lk_i, lk_en_i),
                               ic_act_i, dc_act_i)
                 : pack_cfg(ic_on_i, dc_on_i);

  assign unused_wdata = ^wdata_i[REG_W-1:2];

endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
  import cfc_pkg::*;
#(
  parameter  int IC_LINES = 16,
  parameter  int DC_LINES = 8,
  localparam int IC_IDX_W = $clog2(IC_LINES),
  localparam int DC_IDX_W = $clog2(DC_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_i,
  input  logic                cfg_addr_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  output logic [REG_W-1:0]    cfg_rdata_o,
  input  logic                lock_fn_en_i,
  input  logic                ic_lock_i,
  input  logic                dc_lock_i,
  output logic                ic_allow_o,
  output logic                dc_allow_o,
  output logic                ic_vclr_o,
  output logic [IC_IDX_W-1:0] ic_vclr_idx_o,
  output logic                dc_vclr_o,
  output logic [DC_IDX_W-1:0] dc_vclr_idx_o
);

  // named internal events, visible to the bound checker
  logic ic_req_on, ic_req_off, dc_req_on, dc_req_off;
  logic ic_on, dc_on, ic_act, dc_act;
  logic ic_done, dc_done, ic_refused, dc_refused;

  cfc_regport u_regs (
    .wr_i        (cfg_wr_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .ic_on_i     (ic_on),
    .dc_on_i     (dc_on),
    .ic_act_i    (ic_act),
    .dc_act_i    (dc_act),
    .ic_lk_i     (ic_lock_i),
    .dc_lk_i     (dc_lock_i),
    .lk_en_i     (lock_fn_en_i),
    .rdata_o     (cfg_rdata_o),
    .ic_on_req_o (ic_req_on),
    .ic_off_req_o(ic_req_off),
    .dc_on_req_o (dc_req_on),
    .dc_off_req_o(dc_req_off)
  );

  cfc_flush_engine #(.LINES(IC_LINES), .IDX_W(IC_IDX_W)) u_ic (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_on_i    (ic_req_on),
    .req_off_i   (ic_req_off),
    .on_o        (ic_on),
    .active_o    (ic_act),
    .clr_o       (ic_vclr_o),
    .clr_idx_o   (ic_vclr_idx_o),
    .sweep_done_o(ic_done),
    .on_refused_o(ic_refused)
  );

  cfc_flush_engine #(.LINES(DC_LINES), .IDX_W(DC_IDX_W)) u_dc (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_on_i    (dc_req_on),
    .req_off_i   (dc_req_off),
    .on_o        (dc_on),
    .active_o    (dc_act),
    .clr_o       (dc_vclr_o),
    .clr_idx_o   (dc_vclr_idx_o),
    .sweep_done_o(dc_done),
    .on_refused_o(dc_refused)
  );

  assign ic_allow_o = ic_on;
  assign dc_allow_o = dc_on;

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int IC_LINES = 16,
  parameter int DC_LINES = 8,
  parameter int IC_IDX_W = 4,
  parameter int DC_IDX_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_addr_i,
  input logic [31:0]         cfg_rdata_o,
  input logic                ic_allow_o,
  input logic                dc_allow_o,
  input logic                ic_vclr_o,
  input logic                dc_vclr_o,
  input logic [IC_IDX_W-1:0] ic_vclr_idx_o,
  input logic [DC_IDX_W-1:0] dc_vclr_idx_o,
  input logic                ic_act,
  input logic                dc_act,
  input logic                ic_done,
  input logic                dc_done,
  input logic                ic_refused,
  input logic                dc_refused,
  input logic                ic_req_on,
  input logic                dc_req_on
);

  int ic_run, dc_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ic_run <= 0;
      dc_run <= 0;
    end else begin
      ic_run <= ic_vclr_o ? ic_run + 1 : 0;
      dc_run <= dc_vclr_o ? dc_run + 1 : 0;
    end
  end

  // R2
  ic_allow_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ic_allow_o) |-> $past(ic_req_on));
  // R2
  dc_allow_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dc_allow_o) |-> $past(dc_req_on));
  // R3
  ic_no_allow_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ic_vclr_o && ic_allow_o));
  // R3
  dc_no_allow_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dc_vclr_o && dc_allow_o));
  // R3
  ic_sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ic_vclr_o) |-> ic_vclr_idx_o == '0);
  // R3
  ic_idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_vclr_o && $past(ic_vclr_o)) |-> ic_vclr_idx_o == IC_IDX_W'($past(ic_vclr_idx_o) + 1'b1));
  // R3
  dc_idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_vclr_o && $past(dc_vclr_o)) |-> dc_vclr_idx_o == DC_IDX_W'($past(dc_vclr_idx_o) + 1'b1));
  // R4
  ic_sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ic_vclr_o) |-> ic_run == IC_LINES);
  // R4
  dc_sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_vclr_o) |-> dc_run == DC_LINES);
  // R4
  ic_active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ic_act) |-> $past(ic_done));
  // R4
  dc_active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_act) |-> $past(dc_done));
  // R5
  ic_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_refused |=> !ic_allow_o);
  // R5
  dc_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_refused |=> !dc_allow_o);
  // R7
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr_i |-> cfg_rdata_o[31:4] == '0);

endmodule

bind cfc_ctrl cfc_checker #(
  .IC_LINES(IC_LINES), .DC_LINES(DC_LINES), .IC_IDX_W(IC_IDX_W), .DC_IDX_W(DC_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr_i), .cfg_rdata_o(cfg_rdata_o),
  .ic_allow_o(ic_allow_o), .dc_allow_o(dc_allow_o),
  .ic_vclr_o(ic_vclr_o), .dc_vclr_o(dc_vclr_o),
  .ic_vclr_idx_o(ic_vclr_idx_o), .dc_vclr_idx_o(dc_vclr_idx_o),
  .ic_act(ic_act), .dc_act(dc_act), .ic_done(ic_done), .dc_done(dc_done),
  .ic_refused(ic_refused), .dc_refused(dc_refused),
  .ic_req_on(ic_req_on), .dc_req_on(dc_req_on)
);

// File: tb/tb_cfc_ctrl.sv
`timescale 1ns/1ps
module tb_cfc_ctrl;

  localparam int ICL = 16;
  localparam int DCL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic        lk_en = 1'b0;
  logic        ic_lk = 1'b0;
  logic        dc_lk = 1'b0;
  logic [31:0] rdata;
  logic        ic_allow, dc_allow, ic_vclr, dc_vclr;
  logic [3:0]  ic_idx;
  logic [2:0]  dc_idx;

  always #2.5 clk = ~clk;

  cfc_ctrl #(.IC_LINES(ICL), .DC_LINES(DCL)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .lock_fn_en_i(lk_en), .ic_lock_i(ic_lk), .dc_lock_i(dc_lk),
    .ic_allow_o(ic_allow), .dc_allow_o(dc_allow),
    .ic_vclr_o(ic_vclr), .ic_vclr_idx_o(ic_idx),
    .dc_vclr_o(dc_vclr), .dc_vclr_idx_o(dc_idx)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int ic_q[$];
  int dc_q[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic reg_check(input logic a, input logic [31:0] exp, input string req, input string what);
    addr = a;
    #1;
    chk(req, what, rdata, exp);
  endtask

  task automatic expect_ic_sweep();
    for (int i = 0; i < ICL; i++) ic_q.push_back(i);
  endtask

  task automatic expect_dc_sweep();
    for (int i = 0; i < DCL; i++) dc_q.push_back(i);
  endtask

  // monitor: every clear strobe must match the next predicted index
  always @(negedge clk) begin
    if (rst_n) begin
      if (ic_vclr) begin
        if (ic_q.size() == 0) chk("R10", "unexpected IC clear strobe", 32'd1, 32'd0);
        else begin
          int e;
          e = ic_q.pop_front();
          chk("R3", "IC clear index", 32'(ic_idx), e);
        end
      end
      if (dc_vclr) begin
        if (dc_q.size() == 0) chk("R10", "unexpected DC clear strobe", 32'd1, 32'd0);
        else begin
          int e;
          e = dc_q.pop_front();
          chk("R6", "DC clear index", 32'(dc_idx), e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_check(1'b0, 32'h0, "R1", "cfg after reset");
    reg_check(1'b1, 32'h0, "R1", "status after reset");
    chk("R1", "allows after reset", {30'd0, ic_allow, dc_allow}, 32'd0);
    chk("R1", "strobes after reset", {30'd0, ic_vclr, dc_vclr}, 32'd0);

    // R8 / R7 lock flags
    lk_en = 1'b1; ic_lk = 1'b1; dc_lk = 1'b0;
    reg_check(1'b1, 32'h8, "R8", "IC lock flag at bit 3");
    ic_lk = 1'b0; dc_lk = 1'b1;
    reg_check(1'b1, 32'h4, "R7", "DC lock flag at bit 2");
    lk_en = 1'b0; ic_lk = 1'b1;
    reg_check(1'b1, 32'h0, "R8", "locks hidden when function off");
    ic_lk = 1'b0; dc_lk = 1'b0;

    // R2 enable both
    reg_write(1'b0, 32'h3);
    reg_check(1'b0, 32'h3, "R2", "cfg after enable");
    reg_check(1'b1, 32'h3, "R2", "status after enable");
    chk("R2", "allows after enable", {30'd0, ic_allow, dc_allow}, 32'd3);

    // R9 address map
    reg_write(1'b1, 32'h0);
    reg_check(1'b0, 32'h3, "R9", "write to status ignored");
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_check(1'b0, 32'h3, "R9", "upper cfg bits read 0");

    // R3 / R4 quiet IC sweep
    expect_ic_sweep();
    reg_write(1'b0, 32'h1);
    chk("R3", "IC allow after disable", {31'd0, ic_allow}, 32'd0);
    chk("R6", "DC allow untouched", {31'd0, dc_allow}, 32'd1);
    reg_check(1'b0, 32'h1, "R4", "IC enable bit reads 0 at once");
    n = 0;
    addr = 1'b1;
    #1;
    while (rdata[1] && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R4", "IC active cycles after disable", n, ICL);
    chk("R3", "IC sweep fully seen", ic_q.size(), 32'd0);

    // R5 enable during sweep, R6 overlapping sweeps
    reg_write(1'b0, 32'h3);
    reg_check(1'b0, 32'h3, "R2", "IC re-enabled after sweep");
    expect_ic_sweep();
    reg_write(1'b0, 32'h1);
    repeat (3) @(negedge clk);
    reg_write(1'b0, 32'h3);
    reg_check(1'b0, 32'h1, "R5", "enable during IC sweep dropped");
    chk("R5", "IC allow stays 0", {31'd0, ic_allow}, 32'd0);
    expect_dc_sweep();
    reg_write(1'b0, 32'h0);
    chk("R6", "DC allow after disable", {31'd0, dc_allow}, 32'd0);
    reg_check(1'b1, 32'h3, "R6", "both active while overlapping");
    n = 0;
    addr = 1'b1;
    #1;
    while (rdata[1:0] != 2'b00 && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R6", "IC queue drained", ic_q.size(), 32'd0);
    chk("R6", "DC queue drained", dc_q.size(), 32'd0);
    reg_check(1'b0, 32'h0, "R5", "cfg after both sweeps");
    chk("R5", "IC allow after sweep", {31'd0, ic_allow}, 32'd0);

    // R5 boundary: enable sampled on the last sweep cycle
    reg_write(1'b0, 32'h2);
    reg_check(1'b0, 32'h2, "R2", "IC on, DC off");
    expect_ic_sweep();
    reg_write(1'b0, 32'h0);
    repeat (ICL - 2) @(negedge clk);
    reg_write(1'b0, 32'h2);
    reg_check(1'b0, 32'h0, "R5", "enable on last sweep cycle dropped");
    reg_check(1'b1, 32'h0, "R4", "IC inactive after last sweep cycle");
    chk("R5", "IC allow after boundary write", {31'd0, ic_allow}, 32'd0);
    chk("R3", "boundary sweep fully seen", ic_q.size(), 32'd0);

    // R2 re-enable after the sweep, R10 disabling an idle DC
    reg_write(1'b0, 32'h2);
    chk("R2", "IC allow after re-enable", {31'd0, ic_allow}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R10", "DC stays idle", {31'd0, dc_allow}, 32'd0);
    reg_check(1'b1, 32'h2, "R10", "status shows only IC active");

    summary();
  end

endmodule